// File: doc/BRIEF.md
# MDIO Management Register Engine

This block turns a single 32-bit command word into one clause-22 style management frame on MDC/MDIO toward an external PHY. The host writes the word with an opcode, a PHY address, a register address and, for a write, 16 bits of payload. The engine serialises the frame, drives or releases the shared data line as the frame phase demands, and gathers the returned halfword on a read.

The same word is the status the host reads back. A ready bit clears when a frame is accepted and sets again when the last bit has been clocked out. On a read, the low halfword holds the data that the PHY returned. A one-cycle done pulse marks the end of each frame, so an event flag elsewhere can latch it. MDC is derived from the system clock through a programmable half-period divider.

The host polls the ready bit, with a software timeout, before it issues the next word. Writes that arrive while a frame is running are dropped.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After synchronous reset the command word reads 0, MDC is low, MDIO is not driven (mdio_oe = 0) and mdio_o is 0.
- R2: A write whose opcode field (bits 27:26) is 01 or 10 is accepted when no frame is running. The word's bits 27:0 are stored, the ready bit (bit 28) reads 0 from the next cycle, and a frame starts.
- R3: Every frame is 64 bit times, sent most significant bit first: 32 ones, then the start pattern 01, the opcode, the PHY address (word bits 25:21) and the register address (word bits 20:16).
- R4: On a write (opcode 01) the turnaround is driven as 1 then 0, followed by word bits 15:0 MSB first. mdio_oe stays high for all 64 bit times.
- R5: On a read (opcode 10) mdio_oe is low for both turnaround bits and all 16 data bits. mdio_i is sampled at each MDC rising edge of the data bits and shifted in MSB first. At completion the sampled halfword replaces word bits 15:0.
- R6: MDC stays high for exactly MDC_HALF clock cycles and low for MDC_HALF cycles, for a period of 2*MDC_HALF. The default of 50 gives 2.5 MHz from a 250 MHz clock. MDC is low while idle. MDIO changes only with the MDC falling edge.
- R7: The ready bit sets, and done_pulse is high for exactly one cycle, starting 128*MDC_HALF cycles after the clock edge that accepted the write.
- R8: A write that arrives while a frame is running is ignored. The stored word, the frame in progress and its result are unchanged.
- R9: A write whose opcode is 00 or 11 starts no frame and gives no done pulse. The word's bits 27:0 are stored with the ready bit set.
- R10: Bits 31:29 of the command word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word to write |
| reg_rdata | output | 32 | Current command/status word |
| done_pulse | output | 1 | One-cycle pulse when a frame completes |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | High when the engine drives MDIO |
| mdio_i | input | 1 | Serial data sampled from the PHY |

## Verification
The bound checker watches the following on every cycle:
- The reserved bits stay at zero.
- The done pulse never lasts more than one cycle, and it coincides with a set ready bit.
- MDC is low and the line is released whenever the ready bit is set.
- Every MDC high phase lasts exactly the programmed half period.
- Only a read frame releases the line before it completes.
- An accepted valid write clears the ready bit.

The bench scenarios cover what needs a PHY model and a reference frame: the bit-exact frame contents, the turnaround pattern, the returned read data, the exact completion cycle, the dropping of writes during a frame, and the absence of any frame for an invalid opcode.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_POS     = 46;
    localparam int DAT_POS    = 48;
    localparam int DATA_W     = 16;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic [2:0]        rsvd;
        logic              ready;
        logic [1:0]        op;
        logic [4:0]        phy;
        logic [4:0]        regad;
        logic [DATA_W-1:0] data;
    } mgmt_word_t;

    function automatic logic op_is_valid(input logic [1:0] op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction

    // Full serial image of a frame; read frames carry ones where the line is released.
    function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_word_t w);
        logic [1:0]        ta;
        logic [DATA_W-1:0] pay;
        ta  = (w.op == OP_WRITE) ? 2'b10 : 2'b11;
        pay = (w.op == OP_WRITE) ? w.data : {DATA_W{1'b1}};
        return {{PRE_BITS{1'b1}}, 2'b01, w.op, w.phy, w.regad, ta, pay};
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int HALF = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CNT_W = $clog2(HALF + 1);

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap = run && (cnt == CNT_W'(HALF - 1));
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_serdes.sv
module mdio_serdes
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  is_read,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  last,
    output logic [DATA_W-1:0]     rd_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DAT_POS);

    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      idx;
    logic                  rd_q;

    assign last    = busy && fall && (idx == LAST_IDX);
    assign mdio_o  = busy ? shreg[FRAME_BITS-1] : 1'b0;
    assign mdio_oe = busy && !(rd_q && (idx >= TA_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            shreg   <= '0;
            idx     <= '0;
            rd_q    <= 1'b0;
            rd_data <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            shreg <= frame;
            idx   <= '0;
            rd_q  <= is_read;
        end else if (busy) begin
            if (rise && rd_q && (idx >= DAT_IDX))
                rd_data <= {rd_data[DATA_W-2:0], mdio_i};
            if (fall) begin
                if (idx == LAST_IDX) begin
                    busy <= 1'b0;
                end else begin
                    shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                    idx   <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] reg_rdata,
    output logic        done_pulse,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mgmt_word_t        word_q;
    mgmt_word_t        wr_w;
    logic              busy;
    logic              accept;
    logic              start;
    logic              rise;
    logic              fall;
    logic              last;
    logic [DATA_W-1:0] rd_data;
    logic              unused_bits;

    assign wr_w        = wr_data;
    assign unused_bits = ^{wr_w.rsvd, wr_w.ready};
    assign accept      = wr_en && !busy;
    assign start       = accept && op_is_valid(wr_w.op);
    assign reg_rdata   = word_q;

    mdc_divider #(.HALF(MDC_HALF)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_serdes u_ser (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .frame   (build_frame(wr_w)),
        .is_read (wr_w.op == OP_READ),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .last    (last),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q     <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= last;
            if (accept) begin
                word_q.rsvd  <= '0;
                word_q.ready <= !op_is_valid(wr_w.op);
                word_q.op    <= wr_w.op;
                word_q.phy   <= wr_w.phy;
                word_q.regad <= wr_w.regad;
                word_q.data  <= wr_w.data;
            end else if (last) begin
                word_q.ready <= 1'b1;
                if (word_q.op == OP_READ)
                    word_q.data <= rd_data;
            end
        end
    end
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk #(
    parameter int MDC_HALF = 50
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] reg_rdata,
    input logic        done_pulse,
    input logic        mdc,
    input logic        mdio_oe
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)      hi_cnt <= '0;
        else if (mdc) hi_cnt <= hi_cnt + 1'b1;
        else          hi_cnt <= '0;
    end

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[31:29] == 3'b000);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    // R7
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> reg_rdata[28]);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[28] |-> (!mdc && !mdio_oe));

    // R6
    mdc_high_max_chk: assert property (@(posedge clk) disable iff (rst)
        hi_cnt <= 16'(MDC_HALF));

    // R6
    mdc_high_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc) |-> (hi_cnt == 16'(MDC_HALF)));

    // R5
    release_read_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(mdio_oe) && !reg_rdata[28]) |-> (reg_rdata[27:26] == 2'b10));

    // R2
    accept_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_rdata[28] && (wr_data[27:26] == 2'b01 || wr_data[27:26] == 2'b10))
        |=> !reg_rdata[28]);
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk #(.MDC_HALF(MDC_HALF)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .reg_rdata  (reg_rdata),
    .done_pulse (done_pulse),
    .mdc        (mdc),
    .mdio_oe    (mdio_oe)
);

// File: tb/tb_mdio_cmd_engine.sv
`timescale 1ns/1ps
module tb_mdio_cmd_engine;
    localparam int HALF      = 3;
    localparam int FRAME_CYC = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        mdio_i = 1'b1;
    logic [31:0] reg_rdata;
    logic        done_pulse, mdc, mdio_o, mdio_oe;

    always #2 clk = ~clk;

    mdio_cmd_engine #(.MDC_HALF(HALF)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .reg_rdata(reg_rdata), .done_pulse(done_pulse), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [63:0] frame;
        logic [63:0] oe;
        logic [31:0] regv;
        int          done_cyc;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    function automatic void chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    // PHY model: records driven bits at MDC rise, returns read data after MDC fall
    logic [63:0] cap_o, cap_oe;
    int          rise_n = 0, fall_n = 0;
    logic        cur_rd = 1'b0;
    logic [15:0] cur_rsp = '0;

    always @(posedge mdc) begin
        if (rise_n < 64) begin
            cap_o[63-rise_n]  = mdio_o;
            cap_oe[63-rise_n] = mdio_oe;
        end
        rise_n++;
    end

    always @(negedge mdc) begin
        fall_n++;
        if (cur_rd && fall_n >= 48 && fall_n <= 63) mdio_i = cur_rsp[63-fall_n];
        else                                         mdio_i = 1'b1;
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done_pulse) begin
            if (sbq.size() == 0) begin
                chk("R9 unexpected done pulse", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk({e.tag, " word"}, {32'd0, reg_rdata}, {32'd0, e.regv});
                chk("R3 R4 frame bits", cap_o & e.oe, e.frame & e.oe);
                chk("R4 R5 drive enable", cap_oe, e.oe);
                chk("R7 done cycle", 64'(cyc), 64'(e.done_cyc));
                chk("R6 mdc rising count", 64'(rise_n), 64'd64);
                @(negedge clk);
                chk("R7 pulse width", {63'd0, done_pulse}, 64'd0);
            end
        end
    end

    function automatic logic [63:0] ref_frame(logic [31:0] w);
        logic [1:0] op;
        op = w[27:26];
        return {32'hFFFF_FFFF, 2'b01, op, w[25:21], w[20:16],
                (op == 2'b01) ? {2'b10, w[15:0]} : 18'h0};
    endfunction

    task automatic start_cmd(logic [31:0] w, logic [15:0] rsp, string tag);
        exp_t e;
        @(negedge clk);
        rise_n  = 0;
        fall_n  = 0;
        cur_rd  = (w[27:26] == 2'b10);
        cur_rsp = rsp;
        mdio_i  = 1'b1;
        wr_data = w;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en    = 1'b0;
        e.frame  = ref_frame(w);
        e.oe     = cur_rd ? ~64'h3FFFF : '1;
        e.regv   = {3'b000, 1'b1, w[27:16], cur_rd ? rsp : w[15:0]};
        e.done_cyc = cyc + FRAME_CYC;
        e.tag    = tag;
        sbq.push_back(e);
    endtask

    task automatic wait_idle();
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_tests();
        int t0, t1, t2;
        logic [31:0] w;
        logic        moved;
        repeat (5) @(negedge clk);
        // R1
        chk("R1 reset word", {32'd0, reg_rdata}, 64'd0);
        chk("R1 reset lines", {61'd0, mdc, mdio_oe, mdio_o}, 64'd0);
        rst = 1'b0;

        // R2 R4 R6: write frame, fields stored, ready clear, MDC timing
        w = {4'b0000, 2'b01, 5'h01, 5'h00, 16'hA5C3};
        start_cmd(w, 16'h0, "R4 write");
        @(negedge clk);
        chk("R2 busy word", {32'd0, reg_rdata}, {32'd0, w});
        @(posedge mdc); @(negedge clk); t0 = cyc;
        @(negedge mdc); @(negedge clk); t1 = cyc;
        @(posedge mdc); @(negedge clk); t2 = cyc;
        chk("R6 mdc high time", 64'(t1 - t0), 64'(HALF));
        chk("R6 mdc period", 64'(t2 - t0), 64'(2 * HALF));
        wait_idle();
        chk("R6 idle mdc low", {62'd0, mdc, mdio_oe}, 64'd0);

        // R5: reads with two response patterns
        start_cmd({4'b0000, 2'b10, 5'h1F, 5'h02, 16'h0000}, 16'h1234, "R5 read");
        wait_idle();
        start_cmd({4'b0000, 2'b10, 5'h0A, 5'h15, 16'hFFFF}, 16'h8001, "R5 read edge");
        wait_idle();

        // R10 R8: reserved bits set, second write during frame
        w = {4'b1110, 2'b01, 5'h00, 5'h1F, 16'h0000};
        start_cmd(w, 16'h0, "R10 write");
        repeat (20) @(negedge clk);
        wr_data = {4'b0000, 2'b10, 5'h15, 5'h0A, 16'h5A5A};
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        @(negedge clk);
        chk("R8 word during frame", {32'd0, reg_rdata}, {32'd0, 4'b0000, w[27:0]});
        wait_idle();

        // R9: invalid opcodes 00 and 11
        for (int k = 0; k < 2; k++) begin
            w = {4'b0000, (k == 0) ? 2'b00 : 2'b11, 5'h03, 5'h04, 16'hBEEF};
            @(negedge clk);
            wr_data = w;
            wr_en   = 1'b1;
            @(negedge clk);
            wr_en   = 1'b0;
            moved   = 1'b0;
            for (int c = 0; c < 4 * HALF; c++) begin
                @(negedge clk);
                if (mdc || mdio_oe) moved = 1'b1;
            end
            chk("R9 invalid op word", {32'd0, reg_rdata}, {32'd0, 4'b0001, w[27:0]});
            chk("R9 no frame activity", {63'd0, moved}, 64'd0);
        end
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                vectors++;
                miscompares++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule